// File: doc/BRIEF.md
# Strided Matrix Transfer Engine

This block copies a block of data words between a main-memory port and an on-chip scratchpad on behalf of a processor pipeline. The execute stage hands it one command: a direction flag plus four operands (destination address, source address, element count and stride). The transfer then runs on its own, without involving the pipeline's memory or write-back stages.

In load direction the engine gathers elements from main memory at a programmable stride and packs them into consecutive scratchpad words. This lets a column or a sub-sampled row of a matrix land as a dense vector, without a transpose in memory. In store direction it reads a contiguous scratchpad region and writes it to consecutive memory words; the stride operand plays no part. The element count must be a whole multiple of the current vector length, which arrives on its own input. A count that breaks this rule is refused with an error pulse. The memory port is a valid/ready request channel with a separate read-response strobe. The scratchpad has a write port and a read port with one cycle of read latency.

Top module: `mxfer_engine`

## Requirements
- R1: After reset, busy, done, err, mem_req_valid, sp_we and sp_re are all low.
- R2: A command is taken only in a cycle where cmd_valid is high and busy is low. A cmd_valid while busy is high produces no memory or scratchpad traffic, now or later.
- R3: If vec_len is zero, or cmd_count is not an integer multiple of vec_len, err pulses high for exactly the cycle after the command. Busy stays low, done stays low and no traffic occurs.
- R4: A command with cmd_count zero and a non-zero vec_len raises done for the cycle after the command. Busy stays low and there is no traffic.
- R5: In load direction (cmd_store = 0), read request k (k counting from 0) goes to cmd_src + k*cmd_stride, modulo 2^ADDR_W, in word units. Requests are issued in order of k.
- R6: In load direction, the response data for element k is written to scratchpad word cmd_dst + k.
- R7: In store direction (cmd_store = 1), element k is taken from scratchpad word cmd_src + k and written to memory word cmd_dst + k, whatever cmd_stride holds. Scratchpad read data is taken in the cycle after sp_re.
- R8: At most one memory read is outstanding: no read request is made between a read handshake and its response.
- R9: Once mem_req_valid is high without mem_req_ready, it stays high in the next cycle with unchanged address, write flag and write data.
- R10: Busy is high from the cycle after an accepted non-empty command through the cycle of its final write. The final write is the scratchpad write for a load, or the memory write handshake for a store. Done is high for exactly the cycle after that, with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the execute stage |
| cmd_store | input | 1 | 1 = scratchpad to memory, 0 = memory to scratchpad |
| cmd_dst | input | ADDR_W | Destination word address |
| cmd_src | input | ADDR_W | Source word address |
| cmd_count | input | CNT_W | Number of elements |
| cmd_stride | input | ADDR_W | Word distance between source elements (loads only) |
| vec_len | input | VL_W | Current vector length |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle command rejection pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | DATA_W | Read response data |
| sp_we | output | 1 | Scratchpad write enable |
| sp_waddr | output | ADDR_W | Scratchpad write word address (low bits decoded by the scratchpad) |
| sp_wdata | output | DATA_W | Scratchpad write data |
| sp_re | output | 1 | Scratchpad read enable |
| sp_raddr | output | ADDR_W | Scratchpad read word address |
| sp_rdata | input | DATA_W | Scratchpad read data, valid the cycle after sp_re |

## Verification
A wrong internal pointer shows up at once as a bad address on the next memory request or scratchpad write, so the per-transaction comparison catches it on that element. A corrupted remaining-element count shows as done arriving early or late, or as an extra or missing transaction. The per-cycle busy and done comparison flags this in the cycle where the two part. A wrong state after a refused command shows up in the following cycle as err, done or traffic that the model does not expect.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;

    // Sequencer states: load path and store path share the idle state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_REQ,
        ST_LD_WAIT,
        ST_ST_RD,
        ST_ST_GET,
        ST_ST_REQ
    } xfer_state_t;

    // Outcome of checking a command's count against the vector length.
    typedef enum logic [1:0] {
        CMD_RUN,
        CMD_EMPTY,
        CMD_REJECT
    } cmd_verdict_t;

    // Per-cycle control word from the sequencer to the datapath.
    typedef struct packed {
        logic mem_req;
        logic mem_we;
        logic sp_we;
        logic sp_re;
        logic mem_adv;
        logic sp_adv;
        logic elem_done;
        logic wbuf_load;
    } step_ctl_t;

    localparam step_ctl_t STEP_NONE = '0;

endpackage

// File: rtl/mxfer_validate.sv
module mxfer_validate
    import mxfer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int VL_W  = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [VL_W-1:0]  vlen,
    output cmd_verdict_t     verdict
);
    localparam int DIV_W = (CNT_W > VL_W) ? CNT_W : VL_W;

    logic [DIV_W-1:0] num;
    logic [DIV_W-1:0] den;
    logic [DIV_W-1:0] rem;

    always_comb begin
        num = DIV_W'(count);
        den = DIV_W'(vlen);
        rem = (den == '0) ? '0 : (num % den);
        if (den == '0) begin
            verdict = CMD_REJECT;
        end else if (rem != '0) begin
            verdict = CMD_REJECT;
        end else if (num == '0) begin
            verdict = CMD_EMPTY;
        end else begin
            verdict = CMD_RUN;
        end
    end

endmodule

// File: rtl/mxfer_addr_gen.sv
module mxfer_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              use_stride,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] sp_base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  count,
    input  logic              mem_adv,
    input  logic              sp_adv,
    input  logic              elem_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] sp_addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] UNIT     = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] mem_ptr;
    logic [ADDR_W-1:0] mem_step;
    logic [ADDR_W-1:0] sp_ptr;
    logic [CNT_W-1:0]  remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ptr  <= '0;
            mem_step <= '0;
            sp_ptr   <= '0;
            remain   <= '0;
        end else if (load) begin
            mem_ptr  <= mem_base;
            mem_step <= use_stride ? stride : UNIT;
            sp_ptr   <= sp_base;
            remain   <= count;
        end else begin
            if (mem_adv) begin
                mem_ptr <= mem_ptr + mem_step;
            end
            if (sp_adv) begin
                sp_ptr <= sp_ptr + UNIT;
            end
            if (elem_done) begin
                remain <= remain - CNT_ONE;
            end
        end
    end

    assign mem_addr = mem_ptr;
    assign sp_addr  = sp_ptr;
    assign last     = (remain == CNT_ONE);

endmodule

// File: rtl/mxfer_ctrl.sv
module mxfer_ctrl
    import mxfer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic         cmd_store,
    input  cmd_verdict_t verdict,
    input  logic         mem_req_ready,
    input  logic         mem_rsp_valid,
    input  logic         last,
    output logic         start,
    output step_ctl_t    ctl,
    output logic         busy,
    output logic         done,
    output logic         err
);
    xfer_state_t state;
    xfer_state_t nxt;
    logic        fin;
    logic        rej;
    logic        empty;

    always_comb begin
        nxt   = state;
        ctl   = STEP_NONE;
        start = 1'b0;
        fin   = 1'b0;
        rej   = 1'b0;
        empty = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (verdict)
                        CMD_REJECT: rej = 1'b1;
                        CMD_EMPTY:  empty = 1'b1;
                        default: begin
                            start = 1'b1;
                            nxt   = cmd_store ? ST_ST_RD : ST_LD_REQ;
                        end
                    endcase
                end
            end
            ST_LD_REQ: begin
                ctl.mem_req = 1'b1;
                if (mem_req_ready) begin
                    ctl.mem_adv = 1'b1;
                    nxt         = ST_LD_WAIT;
                end
            end
            ST_LD_WAIT: begin
                if (mem_rsp_valid) begin
                    ctl.sp_we     = 1'b1;
                    ctl.sp_adv    = 1'b1;
                    ctl.elem_done = 1'b1;
                    if (last) begin
                        fin = 1'b1;
                        nxt = ST_IDLE;
                    end else begin
                        nxt = ST_LD_REQ;
                    end
                end
            end
            ST_ST_RD: begin
                ctl.sp_re  = 1'b1;
                ctl.sp_adv = 1'b1;
                nxt        = ST_ST_GET;
            end
            ST_ST_GET: begin
                ctl.wbuf_load = 1'b1;
                nxt           = ST_ST_REQ;
            end
            ST_ST_REQ: begin
                ctl.mem_req = 1'b1;
                ctl.mem_we  = 1'b1;
                if (mem_req_ready) begin
                    ctl.mem_adv   = 1'b1;
                    ctl.elem_done = 1'b1;
                    if (last) begin
                        fin = 1'b1;
                        nxt = ST_IDLE;
                    end else begin
                        nxt = ST_ST_RD;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= fin | empty;
            err   <= rej;
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mxfer_engine.sv
module mxfer_engine
    import mxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int VL_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [VL_W-1:0]   vec_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_waddr,
    output logic [DATA_W-1:0] sp_wdata,
    output logic              sp_re,
    output logic [ADDR_W-1:0] sp_raddr,
    input  logic [DATA_W-1:0] sp_rdata
);
    cmd_verdict_t      verdict;
    step_ctl_t         ctl;
    logic              start;
    logic              last;
    logic [ADDR_W-1:0] mem_base;
    logic [ADDR_W-1:0] sp_base;
    logic [ADDR_W-1:0] mem_ptr;
    logic [ADDR_W-1:0] sp_ptr;
    logic [DATA_W-1:0] wbuf;

    // Direction decides which operand addresses which side.
    assign mem_base = cmd_store ? cmd_dst : cmd_src;
    assign sp_base  = cmd_store ? cmd_src : cmd_dst;

    mxfer_validate #(
        .CNT_W (CNT_W),
        .VL_W  (VL_W)
    ) u_validate (
        .count   (cmd_count),
        .vlen    (vec_len),
        .verdict (verdict)
    );

    mxfer_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_store     (cmd_store),
        .verdict       (verdict),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .last          (last),
        .start         (start),
        .ctl           (ctl),
        .busy          (busy),
        .done          (done),
        .err           (err)
    );

    mxfer_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .use_stride (~cmd_store),
        .mem_base   (mem_base),
        .sp_base    (sp_base),
        .stride     (cmd_stride),
        .count      (cmd_count),
        .mem_adv    (ctl.mem_adv),
        .sp_adv     (ctl.sp_adv),
        .elem_done  (ctl.elem_done),
        .mem_addr   (mem_ptr),
        .sp_addr    (sp_ptr),
        .last       (last)
    );

    // Holds one scratchpad word between its read and its memory write.
    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf <= '0;
        end else if (ctl.wbuf_load) begin
            wbuf <= sp_rdata;
        end
    end

    assign mem_req_valid = ctl.mem_req;
    assign mem_req_we    = ctl.mem_we;
    assign mem_req_addr  = mem_ptr;
    assign mem_req_wdata = wbuf;
    assign sp_we         = ctl.sp_we;
    assign sp_waddr      = sp_ptr;
    assign sp_wdata      = mem_rsp_data;
    assign sp_re         = ctl.sp_re;
    assign sp_raddr      = sp_ptr;

endmodule

// File: rtl/mxfer_engine_chk.sv
module mxfer_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mem_req_valid,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_req_ready,
    input logic              mem_rsp_valid,
    input logic              sp_we,
    input logic [ADDR_W-1:0] sp_waddr,
    input logic              sp_re
);
    logic              rd_open;
    logic              wr_seen;
    logic [ADDR_W-1:0] wr_prev;
    logic              spw_seen;
    logic [ADDR_W-1:0] spw_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_open  <= 1'b0;
            wr_seen  <= 1'b0;
            wr_prev  <= '0;
            spw_seen <= 1'b0;
            spw_prev <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready && !mem_req_we) begin
                rd_open <= 1'b1;
            end else if (mem_rsp_valid) begin
                rd_open <= 1'b0;
            end
            if (!busy) begin
                wr_seen  <= 1'b0;
                spw_seen <= 1'b0;
            end else begin
                if (mem_req_valid && mem_req_ready && mem_req_we) begin
                    wr_seen <= 1'b1;
                    wr_prev <= mem_req_addr;
                end
                if (sp_we) begin
                    spw_seen <= 1'b1;
                    spw_prev <= sp_waddr;
                end
            end
        end
    end

    assert_one_read_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_we) |-> !rd_open);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
             && $stable(mem_req_wdata)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !sp_we && !sp_re));

    assert_err_alone_R3: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !done));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_store_contig_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we && wr_seen) |-> (mem_req_addr == wr_prev + 1'b1));

    assert_sp_contig_R6: assert property (@(posedge clk) disable iff (rst)
        (sp_we && spw_seen) |-> (sp_waddr == spw_prev + 1'b1));

endmodule

bind mxfer_engine mxfer_engine_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .sp_we         (sp_we),
    .sp_waddr      (sp_waddr),
    .sp_re         (sp_re)
);

// File: tb/mxfer_engine_bench.sv
module mxfer_engine_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int VL_W   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_store = 1'b0;
    logic [ADDR_W-1:0] cmd_dst = '0;
    logic [ADDR_W-1:0] cmd_src = '0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic [ADDR_W-1:0] cmd_stride = '0;
    logic [VL_W-1:0]   vec_len = '0;
    logic              busy, done, err;
    logic              mem_req_valid, mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_req_ready = 1'b0;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic              sp_we, sp_re;
    logic [ADDR_W-1:0] sp_waddr, sp_raddr;
    logic [DATA_W-1:0] sp_wdata;
    logic [DATA_W-1:0] sp_rdata = '0;

    mxfer_engine #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W), .VL_W (VL_W)
    ) u_mxfer_engine (
        .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_store (cmd_store),
        .cmd_dst (cmd_dst), .cmd_src (cmd_src), .cmd_count (cmd_count),
        .cmd_stride (cmd_stride), .vec_len (vec_len), .busy (busy), .done (done),
        .err (err), .mem_req_valid (mem_req_valid), .mem_req_we (mem_req_we),
        .mem_req_addr (mem_req_addr), .mem_req_wdata (mem_req_wdata),
        .mem_req_ready (mem_req_ready), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data), .sp_we (sp_we), .sp_waddr (sp_waddr),
        .sp_wdata (sp_wdata), .sp_re (sp_re), .sp_raddr (sp_raddr),
        .sp_rdata (sp_rdata)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
    } txn_t;

    // Behavioural environment and reference model.
    txn_t        spw_q[$];
    txn_t        mw_q[$];
    logic [31:0] rd_q[$];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] spad [0:1023];

    int          checks = 0;
    int          fails  = 0;
    bit          finished = 1'b0;
    bit          exp_busy = 1'b0;
    bit          exp_done = 1'b0;
    bit          exp_err  = 1'b0;
    bit          pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_data = '0;
    bit          rd_prev = 1'b0;
    logic [31:0] rd_prev_addr = '0;
    bit          hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] hold_data = '0;
    bit          hold_we = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction

    task automatic env_drive();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready = lfsr[0] | lfsr[3];
        if (pend && pend_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pend_data;
            pend          = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'h0;
            if (pend) pend_cnt--;
        end
        sp_rdata = rd_prev ? spad[rd_prev_addr[9:0]] : 32'hDEADBEEF;
    endtask

    task automatic env_sample();
        bit   nb, nd, ne;
        txn_t t;
        logic [31:0] ra;
        chk(busy == exp_busy, "R10", "busy", {31'b0, busy}, {31'b0, exp_busy});
        chk(done == exp_done, "R10", "done", {31'b0, done}, {31'b0, exp_done});
        chk(err == exp_err, "R3", "err", {31'b0, err}, {31'b0, exp_err});
        if (hold_pend) begin
            chk(mem_req_valid && mem_req_addr == hold_addr && mem_req_we == hold_we
                && (!hold_we || mem_req_wdata == hold_data), "R9", "request held",
                mem_req_addr, hold_addr);
        end
        hold_pend = mem_req_valid && !mem_req_ready;
        hold_addr = mem_req_addr;
        hold_data = mem_req_wdata;
        hold_we   = mem_req_we;
        nb = exp_busy;
        nd = 1'b0;
        ne = 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                if (mw_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected memory write", mem_req_addr, 32'h0);
                end else begin
                    t = mw_q.pop_front();
                    chk(mem_req_addr == t.a, "R7", "store address", mem_req_addr, t.a);
                    chk(mem_req_wdata == t.d, "R7", "store data", mem_req_wdata, t.d);
                end
                mem[mem_req_addr] = mem_req_wdata;
            end else begin
                chk(!pend, "R8", "read while one outstanding", {31'b0, pend}, 32'h0);
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected memory read", mem_req_addr, 32'h0);
                end else begin
                    ra = rd_q.pop_front();
                    chk(mem_req_addr == ra, "R5", "gather address", mem_req_addr, ra);
                end
                pend      = 1'b1;
                pend_cnt  = int'(lfsr[5:4]) % 3;
                pend_data = memval(mem_req_addr);
            end
        end
        if (sp_we) begin
            if (spw_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected scratchpad write", sp_waddr, 32'h0);
            end else begin
                t = spw_q.pop_front();
                chk(sp_waddr == t.a, "R6", "pack address", sp_waddr, t.a);
                chk(sp_wdata == t.d, "R6", "pack data", sp_wdata, t.d);
            end
            spad[sp_waddr[9:0]] = sp_wdata;
        end
        rd_prev      = sp_re;
        rd_prev_addr = sp_raddr;
        if (exp_busy && spw_q.size() == 0 && mw_q.size() == 0 && rd_q.size() == 0) begin
            nb = 1'b0;
            nd = 1'b1;
        end
        if (cmd_valid && !exp_busy) begin
            if (vec_len == 0 || (int'(cmd_count) % int'(vec_len)) != 0) begin
                ne = 1'b1;
            end else if (cmd_count == 0) begin
                nd = 1'b1;
            end else begin
                nb = 1'b1;
                for (int k = 0; k < int'(cmd_count); k++) begin
                    if (cmd_store) begin
                        t.a = cmd_dst + 32'(k);
                        t.d = spad[10'(cmd_src + 32'(k))];
                        mw_q.push_back(t);
                    end else begin
                        ra = cmd_src + 32'(k) * cmd_stride;
                        rd_q.push_back(ra);
                        t.a = cmd_dst + 32'(k);
                        t.d = memval(ra);
                        spw_q.push_back(t);
                    end
                end
            end
        end
        exp_busy = nb;
        exp_done = nd;
        exp_err  = ne;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) spad[i] = 32'(i) * 32'd3 + 32'd100;
        forever begin
            @(negedge clk);
            env_drive();
            #3;
            if (!rst) env_sample();
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic issue(input bit st, input logic [31:0] dst, input logic [31:0] src,
                         input int cnt, input logic [31:0] stride, input int vl);
        do @(negedge clk); while (busy);
        cmd_store  = st;
        cmd_dst    = dst;
        cmd_src    = src;
        cmd_count  = CNT_W'(cnt);
        cmd_stride = stride;
        vec_len    = VL_W'(vl);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic settle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
        chk(rd_q.size() == 0 && spw_q.size() == 0 && mw_q.size() == 0, "R10",
            "all elements moved", 32'(rd_q.size() + spw_q.size() + mw_q.size()), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        // R1 reset state
        chk(!busy, "R1", "busy after reset", {31'b0, busy}, 32'h0);
        chk(!done && !err, "R1", "done/err after reset", {30'b0, done, err}, 32'h0);
        chk(!mem_req_valid && !sp_we && !sp_re, "R1", "traffic after reset",
            {29'b0, mem_req_valid, sp_we, sp_re}, 32'h0);

        issue(1'b0, 32'h10, 32'h1000, 8, 32'd3, 4);          // R5 R6 strided gather
        settle();
        issue(1'b0, 32'h40, 32'h2000, 4, 32'd1, 4);          // R5 unit stride
        settle();
        issue(1'b0, 32'h60, 32'h3000, 6, 32'hFFFF_FFFF, 2);  // R5 negative stride wrap
        settle();
        issue(1'b1, 32'h8000, 32'h10, 8, 32'd77, 8);         // R7 stride ignored
        settle();
        chk(mem.exists(32'h8007) && !mem.exists(32'h8000 + 32'd77), "R7",
            "store landed contiguously", mem.exists(32'h8007) ? 32'h1 : 32'h0, 32'h1);
        issue(1'b0, 32'h80, 32'h4000, 6, 32'd1, 4);          // R3 not a multiple
        settle();
        issue(1'b0, 32'h80, 32'h4000, 4, 32'd1, 0);          // R3 zero vector length
        settle();
        issue(1'b0, 32'h80, 32'h4000, 0, 32'd1, 4);          // R4 empty command
        settle();
        issue(1'b0, 32'h200, 32'h5000, 4, 32'd2, 1);         // R2 refusal while busy
        repeat (2) @(negedge clk);
        cmd_store = 1'b1; cmd_dst = 32'h9000; cmd_src = 32'h0;
        cmd_count = CNT_W'(4); vec_len = VL_W'(4); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        settle();
        chk(!mem.exists(32'h9000), "R2", "refused store wrote memory",
            mem.exists(32'h9000) ? 32'h1 : 32'h0, 32'h0);
        issue(1'b0, 32'h100, 32'h8000, 8, 32'd1, 8);         // R6 read back stored words
        settle();
        chk(spad[10'h100] == spad[10'h10] && spad[10'h107] == spad[10'h17], "R6",
            "round trip", spad[10'h107], spad[10'h17]);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

endmodule